// File: doc/BRIEF.md
# Streaming A-transpose-A Matrix Engine

This block takes a 4x3 matrix A of signed 8-bit elements, one element per clock, and returns the nine elements of the 3x3 product B = AᵀA, one per clock, on a 16-bit result bus. A one-cycle arm strobe on `load_go` announces a matrix, and the element stream starts on the next cycle. Elements arrive column by column. Products are accumulated while the stream is still arriving, so all six distinct sums are final one cycle after the last element.

B is symmetric, so only b11, b12, b13, b22, b23 and b33 are accumulated. The three mirrored entries are read from the same stored sums. Finished sums are copied into one of two result banks. A fixed delay then releases them in row order, so the first result leaves a constant number of cycles after the first element arrived. A new matrix may be accepted every 15 cycles. Its input phase overlaps the output phase of the previous matrix.

Top module: `ata_engine`

## Requirements
- R1: While `rst_a` is high, and from its release until the first result is due, `out_valid` is 0 and `out_data` is 0. The reset acts without waiting for a clock edge.
- R2: A cycle in which `load_go` is high after a cycle in which it was low arms the engine. The `in_data` of the following cycle is a11. The eleven cycles after that carry a21, a31, a41, a12, a22, a32, a42, a13, a23, a33, a43 in that order. `in_data` outside these twelve cycles has no effect.
- R3: Each result equals the sum over k = 1..4 of a_ki·a_kj. The elements are read as 8-bit two's complement, the sum is formed at 20 bits, and `out_data` carries its low 16 bits.
- R4: Results leave in row order: b11, b12, b13, b21, b22, b23, b31, b32, b33. Each mirrored entry equals its transposed partner.
- R5: b11 is on `out_data` exactly 23 cycles after the cycle that carried a11. The nine results occupy nine consecutive cycles with `out_valid` high, and `out_valid` is low in the cycle after the ninth.
- R6: Whenever `out_valid` is low, `out_data` is zero.
- R7: Matrices whose a11 cycles are 15 cycles apart are all produced correctly, even though each input phase overlaps the previous output phase.
- R8: An arm strobe is ignored when the cycle after it lies fewer than 15 cycles after the last accepted a11 cycle. This includes strobes raised inside an element stream. An ignored strobe and the data that follows it produce no output.
- R9: Sums beyond the 16-bit range wrap modulo 2^16. All elements equal to -128 give 0x0000 for every result, and all elements equal to 127 give 0xFC04.
- R10: A reset raised while a matrix is being loaded or drained discards it. No result from it appears after release, and a matrix armed after release is produced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_a | input | 1 | Asynchronous reset, active high |
| load_go | input | 1 | Arm strobe; its rising cycle precedes the a11 cycle |
| in_data | input | 8 | Matrix element, two's complement, column order |
| out_data | output | 16 | Result element, low 16 bits of the sum |
| out_valid | output | 1 | High while a result is on `out_data` |

## Verification
The hardest case to reach from the ports is a bank conflict. The next matrix must finish accumulating and claim a result bank while the previous matrix is still draining. Only back-to-back matrices at exactly the 15-cycle spacing reach this, so the stimulus sends a train of four matrices with no slack, and each result word is compared on every cycle against a behavioural model. Arm strobes raised mid-stream and one or two cycles too early test the rejection window. A reset raised during the output phase confirms that pending results are dropped.

// File: rtl/ata_pkg.sv
package ata_pkg;
  localparam int ROWS  = 4;
  localparam int COLS  = 3;
  localparam int ELEMS = ROWS * COLS;
  localparam int OUTS  = COLS * COLS;
  localparam int SUMS  = COLS * (COLS + 1) / 2;
  localparam int LANES = 3;

  // sum slots: 0=b11 1=b12 2=b13 3=b22 4=b23 5=b33
  // column during which a slot accumulates (its larger column index)
  function automatic int slot_col(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 1;
      4:       return 2;
      default: return 2;
    endcase
  endfunction

  // product lane: 0 = x*x, 1 = x*stored col1 element, 2 = x*stored col2 element
  function automatic int slot_lane(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 1;
      3:       return 0;
      4:       return 2;
      default: return 0;
    endcase
  endfunction

  // row-order output position -> symmetric sum slot
  function automatic int slot_of_pos(input int p);
    case (p)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 1;
      4:       return 3;
      5:       return 4;
      6:       return 2;
      7:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/ata_intake.sv
module ata_intake
  import ata_pkg::*;
#(
  parameter int II = 15
) (
  input  logic       clk,
  input  logic       rst_a,
  input  logic       load_go,
  output logic       elem_vld,
  output logic [3:0] elem_idx,
  output logic       sums_done
);
  localparam int GAP_W = $clog2(II + 1);
  localparam logic [3:0] LAST_IDX = 4'(ELEMS - 1);

  logic             load_q;
  logic             arm_q;
  logic             cap_q;
  logic [3:0]       idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             done_q;

  // named events
  logic arm_rise;
  logic arm_room;
  logic arm_take;

  assign arm_rise = load_go & ~load_q;
  assign arm_room = (gap_q >= GAP_W'(II - 1));
  assign arm_take = arm_rise & arm_room & ~arm_q;

  assign elem_vld  = arm_q | cap_q;
  assign elem_idx  = arm_q ? 4'd0 : idx_q;
  assign sums_done = done_q;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      load_q <= 1'b0;
      arm_q  <= 1'b0;
      cap_q  <= 1'b0;
      idx_q  <= 4'd0;
      gap_q  <= GAP_W'(II);
      done_q <= 1'b0;
    end else begin
      load_q <= load_go;
      arm_q  <= arm_take;
      done_q <= elem_vld && (elem_idx == LAST_IDX);
      if (arm_q) begin
        gap_q <= GAP_W'(1);
      end else if (gap_q != GAP_W'(II)) begin
        gap_q <= gap_q + GAP_W'(1);
      end
      if (arm_q) begin
        cap_q <= 1'b1;
        idx_q <= 4'd1;
      end else if (cap_q) begin
        idx_q <= idx_q + 4'd1;
        if (idx_q == LAST_IDX) cap_q <= 1'b0;
      end
    end
  end

  AST_ARM_OUTSIDE_STREAM: assert property (@(posedge clk) disable iff (rst_a)
    arm_q |-> !cap_q); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst_a)
    cap_q |-> (idx_q != 4'd0 && idx_q <= LAST_IDX)); // R2
  AST_DONE_FOLLOWS_STREAM: assert property (@(posedge clk) disable iff (rst_a)
    done_q |-> $past(elem_vld)); // R2
endmodule

// File: rtl/ata_mac.sv
module ata_mac
  import ata_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                           clk,
  input  logic                           rst_a,
  input  logic                           elem_vld,
  input  logic [3:0]                     elem_idx,
  input  logic [ELEM_W-1:0]              elem_data,
  output logic [SUMS-1:0][ACC_W-1:0]     sums
);
  logic [1:0] row;
  logic [1:0] col;
  assign row = elem_idx[1:0];
  assign col = elem_idx[3:2];

  function automatic logic signed [ACC_W-1:0] wide_mul(
    input logic signed [ELEM_W-1:0] a,
    input logic signed [ELEM_W-1:0] b
  );
    logic signed [ACC_W-1:0] aw;
    logic signed [ACC_W-1:0] bw;
    aw = {{(ACC_W - ELEM_W){a[ELEM_W-1]}}, a};
    bw = {{(ACC_W - ELEM_W){b[ELEM_W-1]}}, b};
    return aw * bw;
  endfunction

  logic signed [ELEM_W-1:0] keep_q [2][ROWS];
  logic signed [ELEM_W-1:0] x;
  logic signed [ACC_W-1:0]  lane_p [LANES];

  always_comb begin
    x         = $signed(elem_data);
    lane_p[0] = wide_mul(x, x);
    lane_p[1] = wide_mul(x, keep_q[0][row]);
    lane_p[2] = wide_mul(x, keep_q[1][row]);
  end

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < ROWS; r++)
          keep_q[c][r] <= '0;
    end else if (elem_vld && col != 2'd2) begin
      keep_q[col[0]][row] <= x;
    end
  end

  for (genvar s = 0; s < SUMS; s++) begin : g_slot
    localparam logic [1:0] SC = 2'(slot_col(s));
    localparam int         SL = slot_lane(s);
    logic signed [ACC_W-1:0] acc_q;
    always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a) begin
        acc_q <= '0;
      end else if (elem_vld && col == SC) begin
        acc_q <= ((row == 2'd0) ? '0 : acc_q) + lane_p[SL];
      end
    end
    assign sums[s] = acc_q;
  end

  AST_COL_LEGAL: assert property (@(posedge clk) disable iff (rst_a)
    elem_vld |-> (col != 2'd3)); // R2
endmodule

// File: rtl/ata_outseq.sv
module ata_outseq
  import ata_pkg::*;
#(
  parameter int ACC_W   = 20,
  parameter int OUT_W   = 16,
  parameter int LATENCY = 23
) (
  input  logic                       clk,
  input  logic                       rst_a,
  input  logic                       sums_done,
  input  logic [SUMS-1:0][ACC_W-1:0] sums,
  output logic [OUT_W-1:0]           out_data,
  output logic                       out_valid
);
  localparam int WAIT  = LATENCY - ELEMS - 1;
  localparam int DLY_W = $clog2(WAIT + 1);
  localparam logic [3:0] LAST_POS = 4'(OUTS - 1);

  logic             wsel_q;
  logic             pend_q;
  logic             rsel_q;
  logic             act_q;
  logic [3:0]       pos_q;
  logic [DLY_W-1:0] dly_q;

  // named events
  logic       launch;
  logic [2:0] cur_slot;
  logic [ACC_W-1:0] rd_word [2];

  assign launch   = (dly_q == DLY_W'(1));
  assign cur_slot = 3'(slot_of_pos(int'(pos_q)));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ACC_W-1:0] held_q [SUMS];
    always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a) begin
        for (int i = 0; i < SUMS; i++) held_q[i] <= '0;
      end else if (sums_done && wsel_q == 1'(b)) begin
        for (int i = 0; i < SUMS; i++) held_q[i] <= sums[i];
      end
    end
    assign rd_word[b] = held_q[cur_slot];
  end

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      wsel_q <= 1'b0;
      pend_q <= 1'b0;
      rsel_q <= 1'b0;
      act_q  <= 1'b0;
      pos_q  <= 4'd0;
      dly_q  <= '0;
    end else begin
      if (sums_done) begin
        wsel_q <= ~wsel_q;
        pend_q <= wsel_q;
        dly_q  <= DLY_W'(WAIT);
      end else if (dly_q != '0) begin
        dly_q <= dly_q - DLY_W'(1);
      end
      if (launch) begin
        act_q  <= 1'b1;
        pos_q  <= 4'd0;
        rsel_q <= pend_q;
      end else if (act_q) begin
        pos_q <= pos_q + 4'd1;
        if (pos_q == LAST_POS) act_q <= 1'b0;
      end
    end
  end

  assign out_valid = act_q;
  assign out_data  = act_q ? rd_word[rsel_q][OUT_W-1:0] : '0;

  AST_BANK_FREE: assert property (@(posedge clk) disable iff (rst_a)
    sums_done |-> !(act_q && rsel_q == wsel_q)); // R7
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst_a)
    sums_done |-> (dly_q == '0)); // R7
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst_a)
    (act_q && pos_q != LAST_POS) |=> act_q); // R5
  AST_RUN_STOPS: assert property (@(posedge clk) disable iff (rst_a)
    (act_q && pos_q == LAST_POS) |=> !act_q); // R5
endmodule

// File: rtl/ata_engine.sv
module ata_engine
  import ata_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int OUT_W   = 16,
  parameter int ACC_W   = 20,
  parameter int II      = 15,
  parameter int LATENCY = 23
) (
  input  logic              clk,
  input  logic              rst_a,
  input  logic              load_go,
  input  logic [ELEM_W-1:0] in_data,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid
);
  logic                       elem_vld;
  logic [3:0]                 elem_idx;
  logic                       sums_done;
  logic [SUMS-1:0][ACC_W-1:0] sums;

  ata_intake #(.II(II)) u_intake (
    .clk       (clk),
    .rst_a     (rst_a),
    .load_go   (load_go),
    .elem_vld  (elem_vld),
    .elem_idx  (elem_idx),
    .sums_done (sums_done)
  );

  ata_mac #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
    .clk       (clk),
    .rst_a     (rst_a),
    .elem_vld  (elem_vld),
    .elem_idx  (elem_idx),
    .elem_data (in_data),
    .sums      (sums)
  );

  ata_outseq #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LATENCY(LATENCY)) u_outseq (
    .clk       (clk),
    .rst_a     (rst_a),
    .sums_done (sums_done),
    .sums      (sums),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst_a)
    !out_valid |-> (out_data == '0)); // R6
  AST_NO_OUTPUT_DURING_LOAD_START: assert property (@(posedge clk) disable iff (rst_a)
    sums_done |-> $past(elem_vld)); // R5
endmodule

// File: tb/ata_engine_bench.sv
module ata_engine_bench;
  logic        clk = 1'b0;
  logic        rst_a = 1'b0;
  logic        load_go = 1'b0;
  logic [7:0]  in_data = 8'h00;
  wire  [15:0] out_data;
  wire         out_valid;

  always #10 clk = ~clk;

  ata_engine u_ata_engine (
    .clk(clk), .rst_a(rst_a), .load_go(load_go), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  string tag = "R1 R6";
  bit          exp_v [int];
  logic [15:0] exp_d [int];

  // behavioural reference model
  bit m_prev, m_arm, m_rise;
  int m_cnt, m_last, m_sum;
  int m_el [12];

  always @(posedge clk) begin
    if (rst_a) begin
      m_prev = 0; m_arm = 0; m_cnt = 0; m_last = -1000;
      exp_v.delete(); exp_d.delete();
    end else begin
      m_rise = load_go && !m_prev;
      if (m_arm) begin
        m_el[0] = $signed(in_data); m_cnt = 1; m_last = cyc;
      end else if (m_cnt > 0) begin
        m_el[m_cnt] = $signed(in_data);
        m_cnt++;
        if (m_cnt == 12) begin
          for (int p = 0; p < 9; p++) begin
            m_sum = 0;
            for (int k = 0; k < 4; k++)
              m_sum += m_el[(p / 3) * 4 + k] * m_el[(p % 3) * 4 + k];
            exp_v[m_last + 23 + p] = 1'b1;
            exp_d[m_last + 23 + p] = m_sum[15:0];
          end
          m_cnt = 0;
        end
      end
      m_arm  = m_rise && !m_arm && (cyc + 1 - m_last >= 15);
      m_prev = load_go;
    end
    cyc++;
  end

  bit          ev;
  logic [15:0] ed;
  always @(negedge clk) begin
    ev = exp_v.exists(cyc) && !rst_a;
    ed = ev ? exp_d[cyc] : 16'h0000;
    total++;
    if (out_valid !== ev || out_data !== ed) begin
      bad++;
      $display("FAIL %s cycle %0d: valid=%0b data=%h expected valid=%0b data=%h",
               tag, cyc, out_valid, out_data, ev, ed);
    end
  end

  int seed = 7;
  int mat [12];

  function automatic int next_elem(inout int s);
    s = s * 1103515245 + 12345;
    return (s >>> 16) & 255;
  endfunction

  task automatic step(input bit go, input logic [7:0] d);
    @(negedge clk); #1;
    load_go = go; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'hA5);
  endtask

  // arm cycle then twelve elements; optional stray rise at element poke
  task automatic send(input int poke);
    step(1'b1, 8'h5A);
    step(1'b1, 8'(mat[0]));
    for (int i = 1; i < 12; i++) begin
      if (i == poke) step(1'b0, 8'(mat[i]));
      else if (i == poke + 1) step(1'b1, 8'(mat[i]));
      else step(1'b0, 8'(mat[i]));
    end
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 12; i++) mat[i] = next_elem(seed);
  endtask

  task automatic fill_const(input int v0, input int v1, input int v2);
    for (int i = 0; i < 12; i++) mat[i] = (i < 4) ? v0 : ((i < 8) ? v1 : v2);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    #1 rst_a = 1'b1;
    idle(3);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_data !== 16'h0000) begin
      bad++;
      $display("FAIL R1 reset: valid=%0b data=%h expected valid=0 data=0000", out_valid, out_data);
    end
    #1 rst_a = 1'b0;
    idle(4);

    tag = "R2 R3 R4 R5 R6 single";
    fill_rand(); send(0); idle(30);

    tag = "R9 wrap";
    fill_const(-128, -128, -128); send(0); idle(2);
    fill_const(127, 127, 127);    send(0); idle(2);
    fill_const(127, -128, 1);     send(0); idle(30);

    tag = "R7 back-to-back";
    for (int m = 0; m < 4; m++) begin fill_rand(); send(0); idle(2); end
    idle(30);

    tag = "R8 stray rise mid-stream";
    fill_rand(); send(5);
    tag = "R8 early rise gap 13";
    fill_rand(); send(0);
    idle(30);
    fill_rand(); send(0); idle(1);
    tag = "R8 early rise gap 14";
    fill_rand(); send(0); idle(30);

    tag = "R10 reset mid-output";
    fill_rand(); send(0); idle(13);
    rst_a = 1'b1; idle(2); rst_a = 1'b0; idle(30);
    tag = "R10 reset mid-input";
    fill_rand(); send(0);
    rst_a = 1'b1; idle(1); rst_a = 1'b0;
    fill_rand();
    for (int i = 0; i < 3; i++) step(1'b0, 8'(mat[i]));
    idle(30);
    tag = "R10 recovery R3 R4";
    fill_rand(); send(0); idle(2);
    fill_rand(); send(0); idle(40);

    summary();
    $finish;
  end
endmodule